// File: doc/BRIEF.md
# Operand Bypass and Load-Use Stall Controller

This block is the data-hazard control for a five-stage in-order integer pipeline whose stages run fetch, decode, execute, memory, writeback. Results reach the register file only at writeback, so an instruction in execute may need a value that is still travelling down the pipe. For each of the two ALU operands of the instruction in execute, the block compares the source register numbers with the destinations held in the execute/memory and memory/writeback pipeline registers. It then drives a bypass-mux select that picks the newest valid copy of the value.

A loaded value does not exist until the memory stage has finished, so forwarding cannot serve an instruction that sits directly behind a load. The block detects this case in decode by comparing the decode-stage sources with the load held in the decode/execute register. On a hit it stops the PC update, holds the fetch/decode register, and turns the instruction entering execute into a nop. The stall lasts one cycle. The load then sits in memory/writeback, and the dependent instruction takes the value from that bypass. A registered bubble flag records that execute holds a nop in the cycle after a stall, and the block disregards the execute-stage flags in that cycle.

Top module: `hzd_ctrl`

## Requirements
- R1: While reset is active, and after reset with every write-enable and load flag low, both bypass selects are 2'b00, pc_we and ifid_en are 1 and idex_bubble is 0.
- R2: An operand whose source matches exm_rd, with exm_we=1 and exm_ld=0, gets select 2'b10 (execute/memory path) in the same cycle.
- R3: An operand whose source matches mwb_rd with mwb_we=1, and that is not served under R2, gets select 2'b01 (memory/writeback path).
- R4: When both bypass registers target the same source register and both qualify, the younger execute/memory result wins and the select is 2'b10.
- R5: Register number 0 never produces a bypass select other than 2'b00 and never causes a stall.
- R6: Operand A (ex_rs1 to fwd_a) and operand B (ex_rs2 to fwd_b) are resolved independently. Any combination of 2'b00, 2'b01 and 2'b10 can appear on the two selects at once.
- R7: A load held in execute/memory (exm_ld=1) is never a bypass source. Its operand falls through to the memory/writeback path or to the register file.
- R8: If the execute-stage instruction is a load (ex_ld=1, ex_we=1) with a nonzero ex_rd equal to id_rs1 or id_rs2, then pc_we=0, ifid_en=0 and idex_bubble=1 in the same cycle.
- R9: A producer in execute that is not a load, or a load whose destination matches neither decode source, leaves pc_we=1, ifid_en=1 and idex_bubble=0.
- R10: A stall lasts exactly one cycle. In the cycle after idex_bubble was 1, the execute-stage flags are ignored and no stall is raised, whatever ex_ld, ex_we and ex_rd hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| id_rs1 | input | AW | First source register of the decode-stage instruction |
| id_rs2 | input | AW | Second source register of the decode-stage instruction |
| ex_rs1 | input | AW | First source register of the execute-stage instruction |
| ex_rs2 | input | AW | Second source register of the execute-stage instruction |
| ex_rd | input | AW | Destination of the instruction in the decode/execute register |
| ex_we | input | 1 | Register write enable of that instruction |
| ex_ld | input | 1 | That instruction is a load |
| exm_rd | input | AW | Destination held in the execute/memory register |
| exm_we | input | 1 | Write enable held in the execute/memory register |
| exm_ld | input | 1 | Execute/memory register holds a load |
| mwb_rd | input | AW | Destination held in the memory/writeback register |
| mwb_we | input | 1 | Write enable held in the memory/writeback register |
| fwd_a | output | 2 | Operand A select: 00 register file, 10 execute/memory, 01 memory/writeback |
| fwd_b | output | 2 | Operand B select, same encoding |
| pc_we | output | 1 | PC update enable, 0 during a stall |
| ifid_en | output | 1 | Fetch/decode register enable, 0 during a stall |
| idex_bubble | output | 1 | Load nop control bits into the decode/execute register |

## Verification
The assertions assume that every input holds a known value and changes only between rising edges. They also assume that the flags describe pipeline contents at the rising edge that follows. They do not assume that the stimulus behaves like a real pipeline. The select and stall properties are written against arbitrary flag combinations, and the one-cycle stall limit holds even when execute still shows a matching load after a stall. The bench drives every input at the falling edge from a fixed-seed $urandom stream. Register numbers are drawn from a small range so that matches, register-0 cases and double matches come up often. Directed sequences cover the ordinary load-then-use flow through a bubble.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef logic [1:0] fwd_sel_t;
   localparam fwd_sel_t FWD_RF  = 2'b00;
   localparam fwd_sel_t FWD_EXM = 2'b10;
   localparam fwd_sel_t FWD_MWB = 2'b01;
endpackage

// File: rtl/hzd_src_match.sv
// One comparator: does a pipeline-register destination supply this source?
module hzd_src_match #(
   parameter int AW      = 5,
   parameter bit ZERO_HW = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] dst,
   input  logic          dst_we,
   output logic          hit
);
   generate
      if (ZERO_HW) begin : g_zero_hw
         // register 0 reads as constant zero, never produced by anyone
         assign hit = dst_we && (dst == src) && (|src);
      end else begin : g_zero_gpr
         assign hit = dst_we && (dst == src);
      end
   endgenerate
endmodule

// File: rtl/hzd_fwd_pick.sv
// Bypass select for a single execute-stage operand.
module hzd_fwd_pick
   import hzd_pkg::*;
#(
   parameter int AW      = 5,
   parameter bit ZERO_HW = 1'b1
) (
   input  logic [AW-1:0] src,
   input  logic [AW-1:0] exm_rd,
   input  logic          exm_we,
   input  logic          exm_ld,
   input  logic [AW-1:0] mwb_rd,
   input  logic          mwb_we,
   output fwd_sel_t      sel
);
   logic exm_hit;
   logic mwb_hit;
   logic exm_alu_we;

   // a load in execute/memory has no data yet, so it is not a source
   assign exm_alu_we = exm_we && !exm_ld;

   hzd_src_match #(.AW(AW), .ZERO_HW(ZERO_HW)) u_exm (
      .src(src), .dst(exm_rd), .dst_we(exm_alu_we), .hit(exm_hit)
   );
   hzd_src_match #(.AW(AW), .ZERO_HW(ZERO_HW)) u_mwb (
      .src(src), .dst(mwb_rd), .dst_we(mwb_we), .hit(mwb_hit)
   );

   always_comb begin
      if (exm_hit)      sel = FWD_EXM;   // younger result has priority
      else if (mwb_hit) sel = FWD_MWB;
      else              sel = FWD_RF;
   end
endmodule

// File: rtl/hzd_loaduse.sv
// Load-use detection for the instruction sitting in decode.
module hzd_loaduse #(
   parameter int AW      = 5,
   parameter bit ZERO_HW = 1'b1,
   parameter int NSRC    = 2
) (
   input  logic [NSRC-1:0][AW-1:0] id_src,
   input  logic [AW-1:0]           ex_rd,
   input  logic                    ex_we,
   input  logic                    ex_ld,
   input  logic                    ex_valid,
   output logic                    hazard
);
   logic [NSRC-1:0] hits;
   logic            ld_we;

   assign ld_we = ex_valid && ex_ld && ex_we;

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      hzd_src_match #(.AW(AW), .ZERO_HW(ZERO_HW)) u_m (
         .src(id_src[s]), .dst(ex_rd), .dst_we(ld_we), .hit(hits[s])
      );
   end

   assign hazard = |hits;
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
   import hzd_pkg::*;
#(
   parameter int AW      = 5,
   parameter bit ZERO_HW = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] id_rs1,
   input  logic [AW-1:0] id_rs2,
   input  logic [AW-1:0] ex_rs1,
   input  logic [AW-1:0] ex_rs2,
   input  logic [AW-1:0] ex_rd,
   input  logic          ex_we,
   input  logic          ex_ld,
   input  logic [AW-1:0] exm_rd,
   input  logic          exm_we,
   input  logic          exm_ld,
   input  logic [AW-1:0] mwb_rd,
   input  logic          mwb_we,
   output logic [1:0]    fwd_a,
   output logic [1:0]    fwd_b,
   output logic          pc_we,
   output logic          ifid_en,
   output logic          idex_bubble
);
   localparam int NSRC = 2;

   if (AW < 1 || AW > 8) begin : g_bad_aw
      $error("hzd_ctrl: AW must lie in 1..8");
   end

   logic [NSRC-1:0][AW-1:0] ex_src;
   logic [NSRC-1:0][AW-1:0] id_src;
   fwd_sel_t                sel [NSRC];
   logic                    bubble_q;
   logic                    hazard;

   assign ex_src = {ex_rs2, ex_rs1};
   assign id_src = {id_rs2, id_rs1};

   for (genvar o = 0; o < NSRC; o++) begin : g_opnd
      hzd_fwd_pick #(.AW(AW), .ZERO_HW(ZERO_HW)) u_pick (
         .src(ex_src[o]),
         .exm_rd(exm_rd), .exm_we(exm_we), .exm_ld(exm_ld),
         .mwb_rd(mwb_rd), .mwb_we(mwb_we),
         .sel(sel[o])
      );
   end

   assign fwd_a = sel[0];
   assign fwd_b = sel[1];

   // the cycle after a stall, execute holds the inserted nop
   hzd_loaduse #(.AW(AW), .ZERO_HW(ZERO_HW), .NSRC(NSRC)) u_lu (
      .id_src(id_src), .ex_rd(ex_rd), .ex_we(ex_we), .ex_ld(ex_ld),
      .ex_valid(!bubble_q), .hazard(hazard)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bubble_q <= 1'b0;
      else        bubble_q <= hazard;
   end

   assign pc_we       = !hazard;
   assign ifid_en     = !hazard;
   assign idex_bubble = hazard;
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
   parameter int AW      = 5,
   parameter bit ZERO_HW = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] id_rs1,
   input logic [AW-1:0] id_rs2,
   input logic [AW-1:0] ex_rs1,
   input logic [AW-1:0] ex_rs2,
   input logic [AW-1:0] ex_rd,
   input logic          ex_we,
   input logic          ex_ld,
   input logic [AW-1:0] exm_rd,
   input logic          exm_we,
   input logic          exm_ld,
   input logic [AW-1:0] mwb_rd,
   input logic          mwb_we,
   input logic [1:0]    fwd_a,
   input logic [1:0]    fwd_b,
   input logic          pc_we,
   input logic          ifid_en,
   input logic          idex_bubble
);
   a_r6_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a != 2'b11) && (fwd_b != 2'b11));

   a_r4_younger_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (exm_we && !exm_ld && exm_rd == ex_rs1 && ex_rs1 != '0) |-> fwd_a == 2'b10);

   a_r7_load_not_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
      exm_ld |-> (fwd_a != 2'b10 && fwd_b != 2'b10));

   a_r5_zero_no_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (ZERO_HW && ex_rs2 == '0) |-> fwd_b == 2'b00);

   a_r8_loaduse_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_ld && ex_we && ex_rd != '0 && (id_rs1 == ex_rd || id_rs2 == ex_rd)
       && !$past(idex_bubble)) |-> (idex_bubble && !pc_we && !ifid_en));

   a_r9_no_load_no_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !ex_ld |-> (pc_we && ifid_en && !idex_bubble));

   a_r10_single_cycle_stall: assert property (@(posedge clk) disable iff (!rst_n)
      idex_bubble |=> !idex_bubble);
endmodule

bind hzd_ctrl hzd_ctrl_chk #(.AW(AW), .ZERO_HW(ZERO_HW)) u_chk (
   .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
   .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
   .ex_ld(ex_ld), .exm_rd(exm_rd), .exm_we(exm_we), .exm_ld(exm_ld),
   .mwb_rd(mwb_rd), .mwb_we(mwb_we), .fwd_a(fwd_a), .fwd_b(fwd_b),
   .pc_we(pc_we), .ifid_en(ifid_en), .idex_bubble(idex_bubble)
);

// File: tb/sim_hzd_ctrl.sv
module sim_hzd_ctrl;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] id_rs1 = '0, id_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
   logic          ex_we = 1'b0, ex_ld = 1'b0;
   logic [AW-1:0] exm_rd = '0, mwb_rd = '0;
   logic          exm_we = 1'b0, exm_ld = 1'b0, mwb_we = 1'b0;
   logic [1:0]    fwd_a, fwd_b;
   logic          pc_we, ifid_en, idex_bubble;

   int  n_chk = 0;
   int  n_fail = 0;
   bit  done = 1'b0;
   bit  prev_bub = 1'b0;
   bit  next_bub = 1'b0;

   always #2 clk = ~clk;

   hzd_ctrl #(.AW(AW)) u0 (
      .clk(clk), .rst_n(rst_n), .id_rs1(id_rs1), .id_rs2(id_rs2),
      .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd), .ex_we(ex_we),
      .ex_ld(ex_ld), .exm_rd(exm_rd), .exm_we(exm_we), .exm_ld(exm_ld),
      .mwb_rd(mwb_rd), .mwb_we(mwb_we), .fwd_a(fwd_a), .fwd_b(fwd_b),
      .pc_we(pc_we), .ifid_en(ifid_en), .idex_bubble(idex_bubble)
   );

   function automatic logic [1:0] exp_sel(input logic [AW-1:0] s);
      if (s != 0 && exm_we && !exm_ld && exm_rd == s) return 2'b10;
      if (s != 0 && mwb_we && mwb_rd == s)            return 2'b01;
      return 2'b00;
   endfunction

   function automatic bit exp_stall(input bit prev);
      return !prev && ex_ld && ex_we && ex_rd != 0 &&
             (id_rs1 == ex_rd || id_rs2 == ex_rd);
   endfunction

   task automatic check(input string tag, input logic [2:0] got, input logic [2:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s got=%b exp=%b t=%0t", tag, got, exp, $time);
      end
   endtask

   task automatic apply(input string tag,
                        input logic [AW-1:0] i1, i2, e1, e2, erd,
                        input bit ewe, eld,
                        input logic [AW-1:0] xrd, input bit xwe, xld,
                        input logic [AW-1:0] mrd, input bit mwe);
      bit st;
      @(negedge clk);
      prev_bub = next_bub;
      id_rs1 = i1; id_rs2 = i2; ex_rs1 = e1; ex_rs2 = e2; ex_rd = erd;
      ex_we = ewe; ex_ld = eld; exm_rd = xrd; exm_we = xwe; exm_ld = xld;
      mwb_rd = mrd; mwb_we = mwe;
      #1;
      st = exp_stall(prev_bub);
      check({tag, " fwd_a"}, {1'b0, fwd_a}, {1'b0, exp_sel(ex_rs1)});
      check({tag, " fwd_b"}, {1'b0, fwd_b}, {1'b0, exp_sel(ex_rs2)});
      check({tag, " stall"}, {pc_we, ifid_en, idex_bubble}, {!st, !st, st});
      next_bub = st;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 during reset
      check("R1 reset sel", {fwd_a, 1'b0}, 3'b000);
      check("R1 reset stall", {pc_we, ifid_en, idex_bubble}, 3'b110);
      @(negedge clk); rst_n = 1'b1;
      apply("R1 idle", 1, 2, 3, 4, 5, 0, 0, 6, 0, 0, 7, 0);
      apply("R2 exm", 0, 0, 3, 9, 0, 0, 0, 3, 1, 0, 0, 0);
      apply("R3 mwb", 0, 0, 8, 4, 0, 0, 0, 3, 1, 0, 4, 1);
      apply("R4 both", 0, 0, 6, 6, 0, 0, 0, 6, 1, 0, 6, 1);
      apply("R5 zero", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 1);
      apply("R5 zero ld", 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, 0, 0);
      apply("R6 mixed", 0, 0, 11, 12, 0, 0, 0, 11, 1, 0, 12, 1);
      apply("R6 mixed2", 0, 0, 12, 11, 0, 0, 0, 11, 1, 0, 12, 1);
      apply("R7 exm load", 0, 0, 5, 5, 0, 0, 0, 5, 1, 1, 5, 1);
      apply("R7 exm load rf", 0, 0, 5, 2, 0, 0, 0, 5, 1, 1, 9, 1);
      apply("R8 rs1", 7, 3, 0, 0, 7, 1, 1, 0, 0, 0, 0, 0);
      apply("R9 after", 1, 2, 0, 0, 9, 1, 1, 0, 0, 0, 0, 0);
      apply("R8 rs2", 3, 7, 0, 0, 7, 1, 1, 0, 0, 0, 0, 0);
      // R10 execute still shows matching load: must not stall again
      apply("R10 masked", 3, 7, 0, 0, 7, 1, 1, 0, 0, 0, 0, 0);
      apply("R9 alu prod", 3, 7, 0, 0, 7, 1, 0, 0, 0, 0, 0, 0);
      // load-then-use flow: stall, bubble, then memory/writeback bypass
      apply("R8 flow", 10, 0, 0, 0, 10, 1, 1, 0, 0, 0, 0, 0);
      apply("R10 flow bub", 10, 0, 0, 0, 0, 0, 0, 10, 1, 1, 0, 0);
      apply("R3 flow use", 0, 0, 10, 0, 0, 0, 0, 0, 0, 0, 10, 1);
      begin
         int unsigned seed = 32'd1234;
         void'($urandom(seed));
         for (int k = 0; k < 3000; k++) begin
            logic [31:0] r1, r2;
            r1 = $urandom;
            r2 = $urandom;
            apply("R6 random",
                  AW'(r1[1:0]), AW'(r1[3:2]), AW'(r1[5:4]), AW'(r1[7:6]),
                  AW'(r1[9:8]), r1[10], r1[11],
                  AW'(r1[13:12]), r1[14], r2[0] & r2[1],
                  AW'(r1[17:16]), r1[18]);
         end
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule